// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command side of a behavioural parallel NOR flash model. It watches bus write cycles, where a write is any interval with both chip enable and write enable low. It decodes the unlock handshakes and command words that software sends, and acts on a small internal array.

Supported operations are: return to read, identifier readout, single program, grouped program of two words or four bytes, a bypass mode with shortened program sequences, whole-array erase, and block erase. Block erase collects a list of blocks during a restartable acceptance window and can be suspended and resumed.

Programming can only clear bits. A request to raise a bit latches an error, and the error blocks every command except return-to-read. A strap selects word or byte addressing, and this moves the unlock addresses.

Top module: `flash_cmd_seq`

## Requirements
- R1: A bus write is taken when the combined strobe (ce_n and we_n both low) is released, using the address and data last seen while it was held; releasing either pin ends the cycle.
- R2: Data F0h written at any address returns the decoder to array read in that one cycle from any unlock, command or identifier state. A program data cycle treats F0h as data. The erase states are covered by R11 and R12.
- R3: The unlock pair is AAh then 55h. In word mode (byte_mode=0) the addresses are 555h then 2AAh. In byte mode they are AAAh then 555h. Unlock, then A0h at the first address, then one data write programs that location.
- R4: A program stores the bitwise AND of the old and written values. If the written value has a 1 where the stored bit is 0, err is set. After reset every location reads FFh.
- R5: While err is 1, every write except F0h is ignored. F0h clears err.
- R6: Without unlock, 50h at 555h in word mode starts a group of two data writes, and 56h at AAAh in byte mode starts a group of four. Each write programs as in R4. The write after the group is not programmed.
- R7: Unlock then 20h enters bypass (bypass=1). In bypass, A0h at any address then one data write programs a location, and F0h leaves bypass set. 90h then 00h leaves bypass.
- R8: Unlock then 90h raises ids. While ids is 1, rd_data is MAKER at even rd_addr and PART at odd rd_addr. F0h clears ids.
- R9: Unlock, 80h, unlock, then 10h at the first address sets busy. When busy falls, every location reads FFh.
- R10: Unlock, 80h, unlock, then 30h at an address selects that address's block; the block is address bits [5:4] at default size. Each further 30h during the window adds a block and restarts a TMO-cycle window. With a single block, busy is 1 right after the confirm and falls exactly TMO+ERASE_CYC+2 clock edges after the confirm edge. Then only the listed blocks read FFh.
- R11: Any write other than 30h during the window, F0h included, aborts the erase: busy falls at once and no location changes.
- R12: B0h after the window suspends the erase: suspended=1, busy=0, and no time elapses. F0h while suspended leaves it suspended. 30h resumes it, and the erase completes afterwards.
- R13: A write that does not match the expected next step of a sequence returns to read mode without starting anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_mode | input | 1 | 1 selects byte addressing for unlock and grouped program |
| addr | input | AW | Write address |
| wdata | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Array contents or identifier code |
| busy | output | 1 | Erase window or erase in progress |
| suspended | output | 1 | Erase suspended |
| err | output | 1 | Program error latched |
| bypass | output | 1 | Bypass mode active |
| ids | output | 1 | Identifier readout active |

## Verification
Several rules are checked on every cycle: the error flag persists until F0h, stored bits never rise except when an erase completes, suspension survives F0h, busy only starts from an erase confirm or resume, and bypass only ends on a 00h write. The bench scenarios are needed for the rest. They show which sequences are recognised in each addressing mode, the grouped program lengths, the exact erase latency, multi-block selection, abort during the window, and the blocks that stay untouched.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 12,
  parameter int DEPTH = 64,
  parameter int NBLK = 4,
  parameter int TMO = 8,
  parameter int ERASE_CYC = 20,
  parameter logic [7:0] MAKER = 8'h5A,
  parameter logic [7:0] PART = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          byte_mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          suspended,
  output logic          err,
  output logic          bypass,
  output logic          ids
);
  localparam int MAW = $clog2(DEPTH);
  localparam int BW = $clog2(NBLK);
  localparam int BLKW = MAW - BW;
  localparam int CMAX = (TMO > ERASE_CYC) ? TMO : ERASE_CYC;
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [3:0] {IDLE, UL1, UL2, PGM, MULTI, ER1, ER2, ER3,
                            WIN, ERS, SUSP, ASEL, BYP, BYP_PGM, BYP_X} st_t;

  st_t st, nxt;
  logic stb_q;
  logic [AW-1:0] a_q;
  logic [7:0] d_q;
  logic [CW-1:0] cnt;
  logic [1:0] left;
  logic [NBLK-1:0] mask;
  logic [7:0] mem [DEPTH];

  wire stb = !ce_n && !we_n;
  wire commit = stb_q && !stb;
  wire [AW-1:0] u1 = byte_mode ? AW'(12'hAAA) : AW'(12'h555);
  wire [AW-1:0] u2 = byte_mode ? AW'(12'h555) : AW'(12'h2AA);
  wire [MAW-1:0] idx = a_q[MAW-1:0];
  wire [BW-1:0] blk = a_q[MAW-1 -: BW];
  wire [7:0] old = mem[idx];
  wire bad = |(d_q & ~old);
  wire pgm_now = commit && (st == PGM || st == MULTI || st == BYP_PGM);
  wire erase_done = (st == ERS) && (cnt == '0) && !(commit && d_q == 8'hB0);
  wire rst_cmd = commit && d_q == 8'hF0;

  always_comb begin
    nxt = IDLE;
    case (st)
      IDLE: if (!err && a_q == u1) begin
              if (d_q == 8'hAA) nxt = UL1;
              else if (!byte_mode && d_q == 8'h50) nxt = MULTI;
              else if (byte_mode && d_q == 8'h56) nxt = MULTI;
            end
      UL1: if (d_q == 8'h55 && a_q == u2) nxt = UL2;
      UL2: if (a_q == u1)
             case (d_q)
               8'hA0: nxt = PGM;
               8'h80: nxt = ER1;
               8'h90: nxt = ASEL;
               8'h20: nxt = BYP;
               default: nxt = IDLE;
             endcase
      MULTI: nxt = (left == 2'd0 || bad) ? IDLE : MULTI;
      ER1: if (d_q == 8'hAA && a_q == u1) nxt = ER2;
      ER2: if (d_q == 8'h55 && a_q == u2) nxt = ER3;
      ER3: if (d_q == 8'h10 && a_q == u1) nxt = ERS;
           else if (d_q == 8'h30) nxt = WIN;
      ASEL: nxt = (d_q == 8'hF0) ? IDLE : ASEL;
      BYP: if (!err && d_q == 8'hA0) nxt = BYP_PGM;
           else if (!err && d_q == 8'h90) nxt = BYP_X;
           else nxt = BYP;
      BYP_PGM: nxt = BYP;
      BYP_X: nxt = (d_q == 8'h00) ? IDLE : BYP;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      a_q <= '0;
      d_q <= '0;
      st <= IDLE;
      err <= 1'b0;
      cnt <= '0;
      left <= '0;
      mask <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      stb_q <= stb;
      if (stb) begin
        a_q <= addr;
        d_q <= wdata;
      end
      if (pgm_now) begin
        mem[idx] <= old & d_q;
        if (bad) err <= 1'b1;
      end
      if (erase_done)
        for (int i = 0; i < DEPTH; i++)
          if (mask[BW'(i >> BLKW)]) mem[i] <= 8'hFF;
      if (rst_cmd && !(st inside {PGM, MULTI, BYP_PGM, WIN, ERS, SUSP})) err <= 1'b0;
      case (st)
        WIN:
          if (commit) begin
            if (d_q == 8'h30) begin
              mask[blk] <= 1'b1;
              cnt <= CW'(TMO);
            end else begin
              mask <= '0;
              st <= IDLE;
            end
          end else if (cnt == '0) begin
            st <= ERS;
            cnt <= CW'(ERASE_CYC);
          end else cnt <= cnt - 1'b1;
        ERS:
          if (commit && d_q == 8'hB0) st <= SUSP;
          else if (cnt == '0) begin
            st <= IDLE;
            mask <= '0;
          end else cnt <= cnt - 1'b1;
        SUSP:
          if (commit && d_q == 8'h30) st <= ERS;
        default:
          if (commit) begin
            st <= nxt;
            if (st == IDLE && nxt == MULTI) left <= byte_mode ? 2'd3 : 2'd1;
            else if (st == MULTI) left <= left - 1'b1;
            if (st == ER3 && nxt == ERS) begin
              mask <= '1;
              cnt <= CW'(ERASE_CYC);
            end else if (st == ER3 && nxt == WIN) begin
              mask[blk] <= 1'b1;
              cnt <= CW'(TMO);
            end
          end
      endcase
    end
  end

  assign busy = (st == WIN) || (st == ERS);
  assign suspended = (st == SUSP);
  assign bypass = (st == BYP) || (st == BYP_PGM) || (st == BYP_X);
  assign ids = (st == ASEL);
  assign rd_data = ids ? (rd_addr[0] ? PART : MAKER) : mem[rd_addr[MAW-1:0]];
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commit,
  input logic [7:0]    cmd,
  input logic          err,
  input logic          busy,
  input logic          suspended,
  input logic          bypass,
  input logic          ids,
  input logic          erase_done,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data
);
  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(commit && cmd == 8'hF0) |=> err);

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(commit && cmd == 8'hF0));

  p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ids && !$past(ids) && !$past(erase_done) && $stable(rd_addr))
      |-> ((rd_data & ~$past(rd_data)) == 8'h00));

  p_susp_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && commit && cmd == 8'hF0 |=> suspended);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit && (cmd == 8'h30 || cmd == 8'h10)));

  p_byp_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass) |-> $past(commit && cmd == 8'h00));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .cmd(d_q), .err(err),
  .busy(busy), .suspended(suspended), .bypass(bypass), .ids(ids),
  .erase_done(erase_done), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int CLK_NS = 10;
  localparam int TMO = 8;
  localparam int ERC = 20;
  localparam logic [7:0] MAKER = 8'h5A;
  localparam logic [7:0] PART = 8'h3C;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, byte_mode = 0;
  logic [11:0] addr = 0, rd_addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rd_data;
  logic busy, suspended, err, bypass, ids;

  flash_cmd_seq #(.TMO(TMO), .ERASE_CYC(ERC), .MAKER(MAKER), .PART(PART)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .byte_mode(byte_mode),
    .addr(addr), .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .suspended(suspended), .err(err), .bypass(bypass), .ids(ids));

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0] mdl [64];
  bit m_err, m_byp, m_ids, track;
  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && track) begin
      chk("R4 array read", rd_data,
          m_ids ? (rd_addr[0] ? PART : MAKER) : mdl[rd_addr[5:0]]);
      chk("R5 err flag", err, m_err);
      chk("R7 bypass flag", bypass, m_byp);
      chk("R8 ids flag", ids, m_ids);
      chk("R12 suspended idle", suspended, 0);
    end
  end

  function automatic logic [11:0] u1();
    return byte_mode ? 12'hAAA : 12'h555;
  endfunction
  function automatic logic [11:0] u2();
    return byte_mode ? 12'h555 : 12'h2AA;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input bit by_ce = 0);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    if (by_ce) ce_n = 1; else we_n = 1;
    @(posedge clk);
    #1;
    ce_n = 1; we_n = 1;
  endtask

  task automatic mprog(input logic [11:0] a, input logic [7:0] d);
    if (m_err) return;
    if ((d & ~mdl[a[5:0]]) != 0) m_err = 1;
    mdl[a[5:0]] = mdl[a[5:0]] & d;
  endtask

  task automatic unlock(input bit by_ce = 0);
    wr(u1(), 8'hAA, by_ce);
    wr(u2(), 8'h55, by_ce);
  endtask

  task automatic prog(input logic [11:0] a, input logic [7:0] d, input bit by_ce = 0);
    unlock(by_ce);
    wr(u1(), 8'hA0, by_ce);
    wr(a, d, by_ce);
    mprog(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #3;
    v = rd_data;
  endtask

  task automatic erase_setup();
    unlock();
    wr(u1(), 8'h80);
    unlock();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      @(posedge clk);
      #2;
      n++;
    end
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #3;
    chk("R4 reset reads FF", rd_data, 8'hFF);
    chk("R10 reset busy", busy, 0);
    chk("R5 reset err", err, 0);
    track = 1;

    // R3, R4: program then AND
    prog(12'h012, 8'h5A);
    rd(12'h012, v); chk("R3 program word mode", v, 8'h5A);
    prog(12'h012, 8'h50);
    rd(12'h012, v); chk("R4 AND store", v, 8'h50);
    chk("R4 no error", err, 0);
    prog(12'h012, 8'h0F);
    rd(12'h012, v); chk("R4 AND after error", v, 8'h00);
    chk("R4 error raised", err, 1);

    // R5: ignored while error, F0 clears
    prog(12'h020, 8'h00);
    rd(12'h020, v); chk("R5 program ignored", v, 8'hFF);
    wr(12'h003, 8'hF0); m_err = 0;
    chk("R5 cleared", err, 0);
    prog(12'h020, 8'h77);
    rd(12'h020, v); chk("R5 program after clear", v, 8'h77);

    // R13: broken sequence
    wr(12'h555, 8'hAA); wr(12'h123, 8'h55); wr(12'h555, 8'hA0); wr(12'h030, 8'h00);
    rd(12'h030, v); chk("R13 broken unlock", v, 8'hFF);

    // R2: F0 mid-sequence at odd address
    unlock(); wr(12'h7FF, 8'hF0); wr(12'h031, 8'h00);
    rd(12'h031, v); chk("R2 reset mid sequence", v, 8'hFF);

    // R6: double program in word mode
    wr(12'h555, 8'h50); wr(12'h021, 8'h11); mprog(12'h021, 8'h11);
    wr(12'h022, 8'h22); mprog(12'h022, 8'h22);
    wr(12'h023, 8'h00);
    rd(12'h022, v); chk("R6 double second", v, 8'h22);
    rd(12'h023, v); chk("R6 double ends", v, 8'hFF);

    // R3, R1: byte mode via chip-enable release
    byte_mode = 1;
    prog(12'h024, 8'h33, 1);
    rd(12'h024, v); chk("R3 byte mode program", v, 8'h33);
    wr(12'hAAA, 8'h56, 1);
    for (int k = 0; k < 4; k++) begin
      wr(12'h025 + 12'(k), 8'h40 + 8'(k), 1);
      mprog(12'h025 + 12'(k), 8'h40 + 8'(k));
    end
    wr(12'h029, 8'h00, 1);
    rd(12'h028, v); chk("R6 quad fourth", v, 8'h43);
    rd(12'h029, v); chk("R6 quad ends", v, 8'hFF);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h02A, 8'h00);
    rd(12'h02A, v); chk("R3 word unlock rejected in byte mode", v, 8'hFF);
    byte_mode = 0;

    // R8: identifier
    unlock(); wr(12'h555, 8'h90); m_ids = 1;
    rd(12'h000, v); chk("R8 maker", v, MAKER);
    rd(12'h001, v); chk("R8 part", v, PART);
    wr(12'h000, 8'hF0); m_ids = 0;
    chk("R8 exit", ids, 0);

    // R7: bypass
    unlock(); wr(12'h555, 8'h20); m_byp = 1;
    wr(12'h007, 8'hA0); wr(12'h032, 8'h44); mprog(12'h032, 8'h44);
    rd(12'h032, v); chk("R7 bypass program", v, 8'h44);
    wr(12'h100, 8'hF0);
    chk("R7 F0 keeps bypass", bypass, 1);
    wr(12'h009, 8'h90); wr(12'h009, 8'h00); m_byp = 0;
    chk("R7 bypass exit", bypass, 0);
    wr(12'h005, 8'hA0); wr(12'h033, 8'h00);
    rd(12'h033, v); chk("R7 no short program after exit", v, 8'hFF);

    // R10: two blocks in one window
    rd(12'h012, v);
    track = 0;
    erase_setup(); wr(12'h020, 8'h30); wr(12'h030, 8'h30);
    wait_idle(n);
    for (int i = 32; i < 64; i++) mdl[i] = 8'hFF;
    rd(12'h021, v); chk("R10 block 2 erased", v, 8'hFF);
    rd(12'h032, v); chk("R10 block 3 erased", v, 8'hFF);
    rd(12'h012, v); chk("R10 block 1 kept", v, 8'h00);
    track = 1;

    // R11: abort within window
    erase_setup(); wr(12'h010, 8'h30);
    chk("R10 busy after confirm", busy, 1);
    wr(12'h000, 8'hF0);
    chk("R11 abort clears busy", busy, 0);
    repeat (TMO + ERC + 5) @(posedge clk);
    rd(12'h012, v); chk("R11 block unchanged", v, 8'h00);

    // R12: suspend, F0 ignored, resume
    track = 0;
    erase_setup(); wr(12'h010, 8'h30);
    repeat (TMO + 3) @(posedge clk);
    wr(12'h000, 8'hB0);
    chk("R12 suspended", suspended, 1);
    chk("R12 busy low in suspend", busy, 0);
    repeat (ERC + 10) @(posedge clk);
    rd(12'h012, v); chk("R12 no progress while suspended", v, 8'h00);
    wr(12'h000, 8'hF0);
    chk("R12 F0 keeps suspend", suspended, 1);
    wr(12'h000, 8'h30);
    chk("R12 resumed", busy, 1);
    wait_idle(n);
    rd(12'h012, v); chk("R12 erase completes", v, 8'hFF);
    for (int i = 16; i < 32; i++) mdl[i] = 8'hFF;
    track = 1;

    // R10: exact latency for a single block
    prog(12'h015, 8'h00);
    track = 0;
    erase_setup(); wr(12'h010, 8'h30);
    chk("R10 busy at confirm", busy, 1);
    wait_idle(n);
    chk("R10 erase latency", n, TMO + ERC + 2);
    mdl[5'h15] = 8'hFF;
    track = 1;

    // R9: chip erase
    prog(12'h005, 8'h00);
    prog(12'h03F, 8'h00);
    track = 0;
    erase_setup(); wr(12'h555, 8'h10);
    chk("R9 busy", busy, 1);
    wait_idle(n);
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    rd(12'h005, v); chk("R9 low address erased", v, 8'hFF);
    rd(12'h03F, v); chk("R9 high address erased", v, 8'hFF);
    track = 1;
    repeat (4) @(posedge clk);
    finish_up();
  end
endmodule